// File: doc/BRIEF.md
# Clock Gate Control Bank with Separate Set and Clear Aliases

This block holds a small bank of 32-bit clock-gating control words. Each word can be written through two addresses. A write through the set address stops the clocks whose bits are written as 1. A write through the clear address restarts those clocks. Bits written as 0 keep their current value. Software can therefore stop or start any group of clocks with a single store, without reading the word first.

Each state bit drives one gate-enable output, which is high while the clock runs. Each state bit also controls one glitch-free gating cell. The cell captures its enable while its source clock is low, so a gated clock never has a shortened high pulse. A read at either address of a word returns that word's gating state one cycle after the request.

The bank has three words. Word 0 is set through 0x50 and cleared through 0x80. Word 1 is set through 0x54 and cleared through 0x84. Word 2 is set through 0xA0 and cleared through 0xB0. Bit b of word w controls output index w*32+b.

Top module: `clk_gate_bank`

## Requirements
- R1: While reset is active and after it is released, every state bit is 0, every `gate_en_o` bit is 1 and `rdata_o` is 0.
- R2: A write to a word's set address sets, at the next rising clock edge, every state bit whose `wdata_i` bit is 1. Each such bit drives its `gate_en_o` bit low.
- R3: A write to a word's clear address clears, at the next rising clock edge, every state bit whose `wdata_i` bit is 1. Each such bit drives its `gate_en_o` bit high.
- R4: A bit written as 0 through either address keeps its previous value.
- R5: A read request (`req_i`=1, `we_i`=0) at either address of a word puts that word's state on `rdata_o` after the next rising edge. A set bit reads as 1. `rdata_o` holds its value until the next read request.
- R6: A write to any other address changes no state bit. A read from any other address returns 0.
- R7: A write to one word leaves the other words unchanged.
- R8: `gclk_o[i]` is low whenever `src_clk_i[i]` is low. While `src_clk_i[i]` is high, `gclk_o[i]` follows the enable captured during the preceding low phase. A state change during a high phase takes effect only after the next falling edge of the source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write mask data |
| rdata_o | output | 32 | Registered read data |
| src_clk_i | input | 96 | Source clocks, one per gate |
| gate_en_o | output | 96 | Gate enables, 1 = clock running |
| gclk_o | output | 96 | Gated clocks |

## Verification
A write changes the state at the rising edge on which the request is sampled. `gate_en_o` therefore reflects the new state by the following falling edge. A read result is registered, so it is due one rising edge after the request. The bench compares both at every falling edge of `clk_i` against a behavioural model updated at the same rising edges.

Gated clocks are sampled 1 ns inside the high and low phases of a slow source clock. Its edges never coincide with `clk_i` edges. A mid-high-phase change is checked both before and after the next source falling edge.

// File: rtl/cgb_pkg.sv
package cgb_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } cgb_op_e;
endpackage

// File: rtl/cgb_decode.sv
module cgb_decode
  import cgb_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int ADDR_W    = 8,
  parameter logic [NUM_WORDS*ADDR_W-1:0] SET_OFFS = '0,
  parameter logic [NUM_WORDS*ADDR_W-1:0] CLR_OFFS = '0
) (
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output cgb_op_e              op_o [NUM_WORDS],
  output logic [NUM_WORDS-1:0] sel_o
);
  logic wr;
  assign wr = req_i & we_i;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_dec
    logic set_m, clr_m;
    assign set_m    = (addr_i == SET_OFFS[g*ADDR_W +: ADDR_W]);
    assign clr_m    = (addr_i == CLR_OFFS[g*ADDR_W +: ADDR_W]);
    assign sel_o[g] = set_m | clr_m;
    always_comb begin
      op_o[g] = OP_NONE;
      if (wr && set_m)      op_o[g] = OP_SET;
      else if (wr && clr_m) op_o[g] = OP_CLR;
    end
  end
endmodule

// File: rtl/cgb_word.sv
module cgb_word
  import cgb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cgb_op_e           op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else begin
      case (op_i)
        OP_SET:  q_o <= q_o | wdata_i;
        OP_CLR:  q_o <= q_o & ~wdata_i;
        default: ;
      endcase
    end
  end

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SET) |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLR) |=> ((q_o & $past(wdata_i)) == '0));
  p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_NONE) |=> ((q_o & ~$past(wdata_i)) == ($past(q_o) & ~$past(wdata_i))));
  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NONE) |=> $stable(q_o));
endmodule

// File: rtl/cgb_gate_cell.sv
module cgb_gate_cell (
  input  logic rst_ni,
  input  logic clk_src_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_q;

  // transparent while source is low
  always_latch begin
    if (!rst_ni)         en_q = 1'b1;
    else if (!clk_src_i) en_q = en_i;
  end

  assign gclk_o = clk_src_i & en_q;

  p_low_phase_r8: assert property (@(posedge clk_src_i) disable iff (!rst_ni)
    !gclk_o);
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank
  import cgb_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [NUM_WORDS*ADDR_W-1:0] SET_OFFS = {8'hA0, 8'h54, 8'h50},
  parameter logic [NUM_WORDS*ADDR_W-1:0] CLR_OFFS = {8'hB0, 8'h84, 8'h80},
  localparam int NCLK = NUM_WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NCLK-1:0]   src_clk_i,
  output logic [NCLK-1:0]   gate_en_o,
  output logic [NCLK-1:0]   gclk_o
);
  cgb_op_e              op   [NUM_WORDS];
  logic [NUM_WORDS-1:0] sel;
  logic [DATA_W-1:0]    state [NUM_WORDS];
  logic [DATA_W-1:0]    rd_mux;
  logic                 rd_req;

  cgb_decode #(
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W),
    .SET_OFFS(SET_OFFS), .CLR_OFFS(CLR_OFFS)
  ) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .op_o(op), .sel_o(sel)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    cgb_word #(.DATA_W(DATA_W)) u_word (
      .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op[w]),
      .wdata_i(wdata_i), .q_o(state[w])
    );
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int IDX = w * DATA_W + b;
      assign gate_en_o[IDX] = ~state[w][b];
      cgb_gate_cell u_cell (
        .rst_ni(rst_ni), .clk_src_i(src_clk_i[IDX]),
        .en_i(gate_en_o[IDX]), .gclk_o(gclk_o[IDX])
      );
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (sel[w]) rd_mux = rd_mux | state[w];
  end

  assign rd_req = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (rd_req) rdata_o <= rd_mux;
  end

  p_sel_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
  p_rd_unmapped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && sel == '0) |=> (rdata_o == '0));
  p_rd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(rdata_o));
endmodule

// File: tb/clk_gate_bank_tb_top.sv
module clk_gate_bank_tb_top;
  localparam int NW = 3;
  localparam int DW = 32;
  localparam int NC = NW * DW;

  logic          clk_i = 1'b0;
  logic          sclk  = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [7:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [NC-1:0] gate_en_o, gclk_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [DW-1:0] m [NW];
  logic [DW-1:0] rd_exp;
  bit            rd_chk;

  always #4 clk_i = ~clk_i;
  initial begin #3; forever #20 sclk = ~sclk; end

  clk_gate_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .src_clk_i({NC{sclk}}), .gate_en_o(gate_en_o), .gclk_o(gclk_o)
  );

  // word index and alias kind for an address: -1 = unmapped
  function automatic int word_of(input logic [7:0] a, output bit is_set);
    is_set = 1'b0;
    case (a)
      8'h50: begin is_set = 1'b1; return 0; end
      8'h54: begin is_set = 1'b1; return 1; end
      8'hA0: begin is_set = 1'b1; return 2; end
      8'h80: return 0;
      8'h84: return 1;
      8'hB0: return 2;
      default: return -1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model, updated at the same edge the design samples
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NW; w++) m[w] <= '0;
      rd_chk <= 1'b0;
      rd_exp <= '0;
    end else begin
      bit s;
      int w;
      w = word_of(addr_i, s);
      rd_chk <= req_i && !we_i;
      if (req_i && !we_i) rd_exp <= (w < 0) ? '0 : m[w];
      if (req_i && we_i && w >= 0) begin
        if (s) m[w] <= m[w] | wdata_i;
        else   m[w] <= m[w] & ~wdata_i;
      end
    end
  end

  // per-cycle compare
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check("R7 gate_en model", gate_en_o, ~{m[2], m[1], m[0]});
      if (rd_chk) check("R5 rdata model", {{(NC-DW){1'b0}}, rdata_o}, {{(NC-DW){1'b0}}, rd_exp});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    check(tag, {{(NC-DW){1'b0}}, rdata_o}, {{(NC-DW){1'b0}}, exp});
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20;
    check("R1 gate_en in reset", gate_en_o, '1);
    check("R1 rdata in reset", {{(NC-DW){1'b0}}, rdata_o}, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 gate_en after reset", gate_en_o, '1);
    rd(8'h50, 32'h0, "R1 word0 after reset");

    wr(8'h50, 32'h0000_00F0);
    check("R2 gate_en low", {64'b0, gate_en_o[31:0]}, {64'b0, 32'hFFFF_FF0F});
    rd(8'h50, 32'h0000_00F0, "R2 set via 0x50");
    rd(8'h80, 32'h0000_00F0, "R5 read at clear alias");
    wr(8'h50, 32'h0000_0003);
    rd(8'h50, 32'h0000_00F3, "R4 zeros keep bits on set");
    wr(8'h80, 32'h0000_0030);
    rd(8'h80, 32'h0000_00C3, "R3 clear via 0x80");
    rd(8'h50, 32'h0000_00C3, "R4 zeros keep bits on clear");

    wr(8'h54, 32'hFFFF_0000);
    rd(8'h84, 32'hFFFF_0000, "R2 word1 set");
    rd(8'h50, 32'h0000_00C3, "R7 word0 untouched");
    wr(8'hA0, 32'h8000_0001);
    wr(8'hB0, 32'h0000_0001);
    rd(8'hA0, 32'h8000_0000, "R3 word2 clear");
    rd(8'h84, 32'hFFFF_0000, "R7 word1 untouched");
    wr(8'hB0, 32'h8000_0000);
    rd(8'hB0, 32'h0, "R3 word2 cleared");

    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h58, 32'h0, "R6 unmapped read zero");
    rd(8'h50, 32'h0000_00C3, "R6 word0 after unmapped write");
    rd(8'h54, 32'hFFFF_0000, "R6 word1 after unmapped write");
    rd(8'hA0, 32'h0, "R6 word2 after unmapped write");
    check("R6 gate_en after unmapped write", gate_en_o, ~{32'h0, 32'hFFFF_0000, 32'h0000_00C3});

    // R8: gated clock phases
    @(posedge sclk); #1;
    check("R8 running clock high", {95'b0, gclk_o[2]}, 96'd1);
    check("R8 gated clock held low", {95'b0, gclk_o[48]}, 96'd0);
    @(negedge sclk); #1;
    check("R8 low phase all low", gclk_o, '0);
    @(posedge sclk); #1;
    wr(8'h50, 32'h0000_0004);
    check("R8 no truncation mid-high", {95'b0, gclk_o[2]}, 96'd1);
    @(posedge sclk); #1;
    check("R8 stopped after falling edge", {95'b0, gclk_o[2]}, 96'd0);
    wr(8'h80, 32'h0000_0004);
    @(posedge sclk); #1;
    check("R8 restarted", {95'b0, gclk_o[2]}, 96'd1);

    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule